// File: doc/BRIEF.md
# Edge Change Detection Interrupt Unit

This block watches a group of byte-wide digital input ports for transitions. It compares every input line with its value on the previous clock. A low-to-high change counts as a rising event and a high-to-low change counts as a falling event. Each line has its own rising enable bit and its own falling enable bit. A global rising switch and a global falling switch in the control register then qualify the two edge kinds.

Any qualified transition sets a sticky edge flag. A second qualified transition that arrives while the edge flag is still set also sets a sticky overflow flag. Software clears the two flags independently through a clear register. A single level interrupt line is driven from the flags, gated by per-source enables and by a master enable.

Software reaches the block through a byte-wide register bus: a write strobe with address and data, and a combinational read-data path that returns the status byte. The inputs are assumed to be synchronized and, where needed, filtered before they reach the block.

Top module: `ecd_irq_unit`

## Requirements
- R1: While `rst` is high and afterwards until software writes, the control register, all per-line enables and both status flags are zero; `irq` is low and a status read returns 0x00.
- R2: When the control register has bit 3 set and a line's rising enable bit is set, a 0→1 change of that line on `din` sets status bit 0 (edge) at the next clock edge.
- R3: When the control register has bit 4 set and a line's falling enable bit is set, a 1→0 change of that line sets status bit 0 at the next clock edge.
- R4: A change on a line whose enable bit for that direction is clear, or a change whose direction has its global control bit (3 rising, 4 falling) clear, leaves the status unchanged.
- R5: A qualified change that occurs while status bit 0 is already set sets status bit 1 (overflow).
- R6: A write to address 0x01 clears the edge flag when data bit 3 is set and clears the overflow flag when data bit 2 is set; each flag is cleared independently of the other.
- R7: If a qualified change and a clear of the same flag fall in the same cycle, the flag ends up set.
- R8: Status bit 2 (pending) equals control bit 2 (master) AND ((edge AND control bit 0) OR (overflow AND control bit 1)), and `irq` always equals the pending bit.
- R9: After zero is written to the control register (address 0x03), `irq` is low and no change sets any flag.
- R10: Port n's rising enable byte is written at address 0x42+16n and its falling enable byte at 0x43+16n. Control is written at 0x03 and status is read at 0x02. `bus_rdata` is 0x00 at any other address, and writes to unused addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Status byte when `bus_addr` is 0x02, otherwise 0x00 |
| din | input | NUM_PORTS*8 | Synchronized input lines, port n in bits 8n+7..8n |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the unit with NUM_PORTS set to 3. With this setting, address 0x72 (where a fourth port's rising byte would sit) is unmapped, so a write there can be shown to have no effect. Three ports are enough to place rising-only, falling-only and mixed enable patterns on separate bytes. They also let changes occur on several ports in the same cycle. A behavioural model checks `irq` and the status read on every clock through clears that collide with new events, master and per-source masking, and a zeroed control register.

// File: rtl/ecd_pkg.sv
package ecd_pkg;

    localparam int PORT_W = 8;

    localparam logic [7:0] A_CLEAR  = 8'h01;
    localparam logic [7:0] A_STATUS = 8'h02;
    localparam logic [7:0] A_CTRL   = 8'h03;

    localparam int PORT_BASE   = 'h40;
    localparam int PORT_STRIDE = 16;
    localparam int OFS_RISE    = 2;
    localparam int OFS_FALL    = 3;

    localparam int CLR_OVF_BIT  = 2;
    localparam int CLR_EDGE_BIT = 3;

    // control byte, bit 0 at the bottom
    typedef struct packed {
        logic fall_ie;   // 4
        logic rise_ie;   // 3
        logic master;    // 2
        logic ovf_ie;    // 1
        logic edge_ie;   // 0
    } ctrl_t;

    typedef struct packed {
        logic pending;   // 2
        logic ovf;       // 1
        logic edge_seen; // 0
    } stat_t;

    function automatic logic [7:0] port_addr(input int port, input int ofs);
        return 8'(PORT_BASE + PORT_STRIDE * port + ofs);
    endfunction

endpackage

// File: rtl/ecd_regs.sv
module ecd_regs
    import ecd_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int W = NUM_PORTS * PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [7:0]   addr,
    input  logic [7:0]   wdata,
    output ctrl_t        ctrl,
    output logic [W-1:0] rise_en,
    output logic [W-1:0] fall_en,
    output logic         clr_edge,
    output logic         clr_ovf
);

    logic ctrl_wr;
    assign ctrl_wr = wr && (addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            rise_en <= '0;
            fall_en <= '0;
        end else begin
            if (ctrl_wr)
                ctrl <= ctrl_t'(wdata[4:0]);
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (wr && (addr == port_addr(p, OFS_RISE)))
                    rise_en[p*PORT_W +: PORT_W] <= wdata;
                if (wr && (addr == port_addr(p, OFS_FALL)))
                    fall_en[p*PORT_W +: PORT_W] <= wdata;
            end
        end
    end

    assign clr_edge = wr && (addr == A_CLEAR) && wdata[CLR_EDGE_BIT];
    assign clr_ovf  = wr && (addr == A_CLEAR) && wdata[CLR_OVF_BIT];

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(ctrl)); // R10

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (ctrl == ctrl_t'($past(wdata[4:0])))); // R9

endmodule

// File: rtl/ecd_detect.sv
module ecd_detect
    import ecd_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int W = NUM_PORTS * PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic         rise_ie,
    input  logic         fall_ie,
    output logic         edge_ev
);

    logic [W-1:0]         din_q;
    logic [NUM_PORTS-1:0] rise_hit;
    logic [NUM_PORTS-1:0] fall_hit;

    // loading during reset keeps the first compare free of false edges
    always_ff @(posedge clk) begin
        din_q <= din;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [PORT_W-1:0] cur, prv;
        assign cur = din[p*PORT_W +: PORT_W];
        assign prv = din_q[p*PORT_W +: PORT_W];
        assign rise_hit[p] = |(cur & ~prv & rise_en[p*PORT_W +: PORT_W]);
        assign fall_hit[p] = |(~cur & prv & fall_en[p*PORT_W +: PORT_W]);
    end

    assign edge_ev = (rise_ie && (|rise_hit)) || (fall_ie && (|fall_hit));

    AST_QUIET_INPUT: assert property (@(posedge clk) disable iff (rst)
        $stable(din) |-> !edge_ev); // R4

    AST_NO_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (!rise_ie && !fall_ie) |-> !edge_ev); // R9

endmodule

// File: rtl/ecd_status.sv
module ecd_status
    import ecd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  edge_ev,
    input  logic  clr_edge,
    input  logic  clr_ovf,
    input  logic  edge_ie,
    input  logic  ovf_ie,
    input  logic  master,
    output stat_t stat,
    output logic  irq
);

    logic edge_q, ovf_q;

    // a new event takes priority over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (edge_ev)
                edge_q <= 1'b1;
            else if (clr_edge)
                edge_q <= 1'b0;
            if (edge_ev && edge_q)
                ovf_q <= 1'b1;
            else if (clr_ovf)
                ovf_q <= 1'b0;
        end
    end

    assign stat.edge_seen = edge_q;
    assign stat.ovf       = ovf_q;
    assign stat.pending   = master && ((edge_q && edge_ie) || (ovf_q && ovf_ie));
    assign irq            = stat.pending;

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
        edge_ev |=> edge_q); // R2

    AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (rst)
        (edge_ev && edge_q) |=> ovf_q); // R5

    AST_OVERFLOW_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> $past(edge_q)); // R5

    AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_edge && !edge_ev) |=> !edge_q); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (clr_edge && edge_ev) |=> edge_q); // R7

    AST_IRQ_MASTER: assert property (@(posedge clk) disable iff (rst)
        !master |-> !irq); // R8

endmodule

// File: rtl/ecd_irq_unit.sv
module ecd_irq_unit
    import ecd_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int W = NUM_PORTS * PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_wr,
    input  logic [7:0]   bus_addr,
    input  logic [7:0]   bus_wdata,
    output logic [7:0]   bus_rdata,
    input  logic [W-1:0] din,
    output logic         irq
);

    ctrl_t        ctrl;
    stat_t        stat;
    logic [W-1:0] rise_en, fall_en;
    logic         clr_edge, clr_ovf, edge_ev;

    ecd_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .ctrl     (ctrl),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .clr_edge (clr_edge),
        .clr_ovf  (clr_ovf)
    );

    ecd_detect #(.NUM_PORTS(NUM_PORTS)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .rise_ie (ctrl.rise_ie),
        .fall_ie (ctrl.fall_ie),
        .edge_ev (edge_ev)
    );

    ecd_status u_status (
        .clk      (clk),
        .rst      (rst),
        .edge_ev  (edge_ev),
        .clr_edge (clr_edge),
        .clr_ovf  (clr_ovf),
        .edge_ie  (ctrl.edge_ie),
        .ovf_ie   (ctrl.ovf_ie),
        .master   (ctrl.master),
        .stat     (stat),
        .irq      (irq)
    );

    assign bus_rdata = (bus_addr == A_STATUS) ? {5'b0, stat} : 8'h00;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && bus_rdata[1:0] == 2'b00)); // R1

endmodule

// File: tb/ecd_irq_unit_bench.sv
module ecd_irq_unit_bench;

    localparam int CLK_P = 10;
    localparam int NP    = 3;
    localparam int W     = NP * 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = 8'h02;
    logic [7:0]   bus_wdata = 8'h00;
    logic [7:0]   bus_rdata;
    logic [W-1:0] din = '0;
    logic         irq;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    // reference model state
    logic [7:0]   m_ctrl = 8'h00;
    logic [7:0]   m_rise [NP];
    logic [7:0]   m_fall [NP];
    logic [W-1:0] m_prev = '0;
    logic         m_edge = 1'b0;
    logic         m_ovf  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ecd_irq_unit #(.NUM_PORTS(NP)) u_ecd_irq_unit (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .din       (din),
        .irq       (irq)
    );

    task automatic compare();
        logic       pend;
        logic [7:0] exp_rd;
        pend   = m_ctrl[2] && ((m_edge && m_ctrl[0]) || (m_ovf && m_ctrl[1]));
        exp_rd = (bus_addr == 8'h02) ? {5'b0, pend, m_ovf, m_edge} : 8'h00;
        checks++;
        if (irq !== pend) begin
            errors++;
            $display("FAIL %s irq actual %0b expected %0b at %0t", phase, irq, pend, $time);
        end
        checks++;
        if (bus_rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s rdata actual %02h expected %02h at %0t", phase, bus_rdata, exp_rd, $time);
        end
    endtask

    task automatic tick();
        logic       rh = 1'b0, fh = 1'b0, ev, clr;
        logic       n_edge, n_ovf;
        logic [7:0] n_ctrl;
        logic [7:0] n_rise [NP];
        logic [7:0] n_fall [NP];
        n_ctrl = m_ctrl;
        for (int p = 0; p < NP; p++) begin
            n_rise[p] = m_rise[p];
            n_fall[p] = m_fall[p];
            for (int b = 0; b < 8; b++) begin
                if (din[p*8+b] && !m_prev[p*8+b] && m_rise[p][b]) rh = 1'b1;
                if (!din[p*8+b] && m_prev[p*8+b] && m_fall[p][b]) fh = 1'b1;
            end
        end
        ev  = (rh && m_ctrl[3]) || (fh && m_ctrl[4]);
        clr = bus_wr && (bus_addr == 8'h01);
        n_edge = ev ? 1'b1 : (clr && bus_wdata[3]) ? 1'b0 : m_edge;
        n_ovf  = (ev && m_edge) ? 1'b1 : (clr && bus_wdata[2]) ? 1'b0 : m_ovf;
        if (bus_wr) begin
            if (bus_addr == 8'h03) n_ctrl = bus_wdata & 8'h1F;
            for (int p = 0; p < NP; p++) begin
                if (bus_addr == 8'(8'h42 + 16*p)) n_rise[p] = bus_wdata;
                if (bus_addr == 8'(8'h43 + 16*p)) n_fall[p] = bus_wdata;
            end
        end
        if (rst) begin
            n_ctrl = 8'h00;
            n_edge = 1'b0;
            n_ovf  = 1'b0;
            for (int p = 0; p < NP; p++) begin
                n_rise[p] = 8'h00;
                n_fall[p] = 8'h00;
            end
        end
        @(posedge clk);
        #1;
        m_ctrl = n_ctrl;
        m_edge = n_edge;
        m_ovf  = n_ovf;
        m_prev = din;
        for (int p = 0; p < NP; p++) begin
            m_rise[p] = n_rise[p];
            m_fall[p] = n_fall[p];
        end
        compare();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        tick();
        bus_wr    = 1'b0;
        bus_addr  = 8'h02;
        bus_wdata = 8'h00;
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_rise[p] = 8'h00;
            m_fall[p] = 8'h00;
        end
        // R1: reset state, inputs moving with nothing enabled
        phase = "R1";
        tick();
        tick();
        rst = 1'b0;
        tick();
        din = '1; tick();
        din = '0; tick();

        // R10: enable bytes per port, writes to unused addresses
        phase = "R10";
        wr(8'h42, 8'h01);
        wr(8'h53, 8'h80);
        wr(8'h62, 8'hF0);
        wr(8'h72, 8'hFF);
        wr(8'h44, 8'hFF);
        wr(8'h02, 8'h1F);
        bus_addr = 8'h10; tick();
        bus_addr = 8'h02;

        // R9: control still zero, enabled lines toggle without effect
        phase = "R9";
        din = 24'h000001; tick();
        din = 24'h000000; tick();

        // R2: rising on port 0 bit 0
        phase = "R2";
        wr(8'h03, 8'h1F);
        din = 24'h000001; tick();
        tick();

        // R6: clear edge
        phase = "R6";
        wr(8'h01, 8'h08);

        // R3: falling on port 1 bit 7
        phase = "R3";
        din = 24'h008001; tick();
        din = 24'h000001; tick();

        // R5: second event while edge still set
        phase = "R5";
        din = 24'h000000; tick();
        din = 24'h000001; tick();

        // R6: clear overflow alone, then edge alone
        phase = "R6";
        wr(8'h01, 8'h04);
        tick();
        din = 24'h000000; tick();
        din = 24'h000001; tick();
        wr(8'h01, 8'h08);
        tick();
        wr(8'h01, 8'h0C);

        // R4: unenabled lines and directions, global rising switch off
        phase = "R4";
        din = 24'h0F8003; tick();
        wr(8'h03, 8'h17);
        din = 24'h1F8003; tick();
        din = 24'h0F8003; tick();
        wr(8'h03, 8'h1F);

        // R7: clear in the same cycle as a new event
        phase = "R7";
        din = 24'h2F8003; tick();
        din = 24'h6F8003;
        wr(8'h01, 8'h0C);
        tick();

        // R8: master and per-source enables
        phase = "R8";
        wr(8'h03, 8'h1B);
        tick();
        wr(8'h03, 8'h1E);
        wr(8'h01, 8'h04);
        tick();
        wr(8'h03, 8'h1D);
        din = 24'hEF8003; tick();
        wr(8'h03, 8'h1F);

        // R9: control back to zero
        phase = "R9";
        wr(8'h03, 8'h00);
        wr(8'h01, 8'h0C);
        din = 24'h000000; tick();
        din = 24'hFFFFFF; tick();
        tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        errors++;
        $display("FAIL watchdog expired in phase %s", phase);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule